// File: doc/BRIEF.md
# Multi-Mode Event Profiling Counter

This block is a profiling counter for on-chip analysis. One input of an event vector is selected as the count source. If no input is selected, the count source is every clock cycle. The counter adds one for each cycle the source is high (duration counting) or for each rising edge of the source (edge counting). It only ever counts upward, and software-visible registers are out of scope: the configuration arrives on plain input pins and the results leave on plain output pins.

Five operating modes share the counter:

- **Free-running:** wraps with a sticky overflow flag.
- **Timer:** runs against a reference value.
- **Gated:** counting is opened and closed by two selectable events.
- **Peak:** keeps the longest gated window over many iterations.
- **Accumulate:** sums gated windows without clearing between them.

In every mode the block emits a one-cycle match pulse when the count reaches the reference value.

Top module: `event_profile_counter`

## Requirements
- R1: A synchronous active-low reset clears `count`, `max_count`, `overflow`, `match` and `running` to zero. Apart from the clears named below, `count` never decreases.
- R2: Source selection:
  - `cnt_sel` = 0 makes every clock cycle a count source.
  - `cnt_sel` = k, for 1 ≤ k ≤ NUM_EV, selects `ev_in[k-1]`.
  - A larger `cnt_sel` value selects nothing, and the counter does not advance.
- R3: With `edge_mode` = 0 (duration), the count advances by one on each clock edge at which the selected input is high.
- R4: With `edge_mode` = 1 (edge), the count advances by one only on an edge at which the selected input is high and was low at the previous edge. An input held high for 25 cycles adds 1, where duration counting would add 25.
- R5: In free-running mode (`mode_sel` = 0), an advance from the all-ones value wraps `count` to zero and sets `overflow`. `overflow` stays set until `ovf_clr` is sampled high. When a wrap and a clear occur on the same edge, the flag is set.
- R6: `match` is high for exactly the one cycle after an edge at which the count advances onto `ref_val`. In timer mode with the return option, this is the advance that would reach `ref_val`.
- R7: In timer mode (`mode_sel` = 1):
  - With `timer_hold` = 0, the advance that would reach `ref_val` loads zero instead, so the count cycles through 0 to `ref_val`-1.
  - With `timer_hold` = 1, the count moves on past `ref_val`.
- R8: Gated modes (`mode_sel` = 2, 3, 4):
  - The count advances only while `running` is high.
  - A start is a rising edge of `ev_in[start_sel]`, and it sets `running`.
  - A stop is a rising edge of `ev_in[stop_sel]`, and it clears `running`.
  - Starts seen while running are ignored.
  - Neither the start edge nor the stop edge itself adds a count.
- R9: In gated mode 2, an accepted start clears `count` to zero, and a stop holds the reached value.
- R10: In peak mode (`mode_sel` = 3), at each stop `max_count` takes the current count if that count is larger, and `count` returns to zero.
- R11: In accumulate mode (`mode_sel` = 4):
  - A stop freezes `count`.
  - The next start resumes counting from the frozen value without a clear.
  - `max_count` is never changed.
- R12: If start and stop arrive on the same edge while the counter is idle in a gated mode, the start is accepted and the stop is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_in | input | NUM_EV | Event vector |
| cnt_sel | input | SEL_W | Count source select (0 = every cycle, k = ev_in[k-1]) |
| edge_mode | input | 1 | 0 = duration counting, 1 = rising-edge counting |
| mode_sel | input | 3 | 0 free-running, 1 timer, 2 gated, 3 peak, 4 accumulate |
| timer_hold | input | 1 | Timer mode: 1 keeps counting past the reference, 0 returns to zero |
| start_sel | input | IDX_W | Index of the start event in ev_in |
| stop_sel | input | IDX_W | Index of the stop event in ev_in |
| ref_val | input | CNT_W | Reference value for match and timer |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| count | output | CNT_W | Current count |
| max_count | output | CNT_W | Longest window seen in peak mode |
| overflow | output | 1 | Sticky wrap flag |
| match | output | 1 | One-cycle pulse on reaching the reference |
| running | output | 1 | Gated counting window is open |

## Verification
Each result has a fixed latency, counted in clock edges from the stimulus:

- An input level held across a clock edge changes `count`, `match`, `running` and `overflow` at that same edge, with no extra stage.
- A start or stop pulse changes `running` at the edge that samples it.
- `max_count` and the clear in peak mode are updated at the stop edge.
- The first counted cycle of a gated window is the edge after the start.

The bench changes inputs and samples outputs only on falling clock edges. A stimulus that is held for n rising edges is therefore checked at the falling edge that follows the n-th of them, before any further edge can move the result.

// File: rtl/epc_pkg.sv
`timescale 1ns/1ps
// Shared types for the event profiling counter.
package epc_pkg;
    typedef enum logic [2:0] {
        MODE_FREE   = 3'd0,
        MODE_TIMER  = 3'd1,
        MODE_GATED  = 3'd2,
        MODE_PEAK   = 3'd3,
        MODE_ACCUM  = 3'd4
    } cnt_mode_e;
endpackage

// File: rtl/epc_event_front.sv
`timescale 1ns/1ps
// Event front end: registers the event vector once to find rising edges, then
// derives the count tick and the start/stop hits.
// Assumes ev_in is synchronous to clk.
module epc_event_front #(
    parameter int NUM_EV = 8,
    parameter int SEL_W  = 4,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EV-1:0] ev_in,
    input  logic [SEL_W-1:0]  cnt_sel,
    input  logic              edge_mode,
    input  logic [IDX_W-1:0]  start_sel,
    input  logic [IDX_W-1:0]  stop_sel,
    output logic              tick,
    output logic              start_hit,
    output logic              stop_hit
);
    logic [NUM_EV-1:0] ev_q;
    logic [NUM_EV-1:0] rise;

    // Hold last cycle's event levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ev_q <= '0;
        else        ev_q <= ev_in;
    end

    assign rise = ev_in & ~ev_q;

    // Pick the count source and apply duration or edge qualification.
    always_comb begin
        tick = (cnt_sel == '0);
        for (int i = 0; i < NUM_EV; i++) begin
            if (cnt_sel == SEL_W'(i + 1)) tick = edge_mode ? rise[i] : ev_in[i];
        end
    end

    // Pick the start and stop events; both are edge-qualified.
    always_comb begin
        start_hit = 1'b0;
        stop_hit  = 1'b0;
        for (int i = 0; i < NUM_EV; i++) begin
            if (start_sel == IDX_W'(i)) start_hit = rise[i];
            if (stop_sel  == IDX_W'(i)) stop_hit  = rise[i];
        end
    end

    // R4: in edge mode a held source cannot tick on two consecutive edges.
    a_r4_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && edge_mode && cnt_sel != '0) ##1 ($stable(cnt_sel) && $stable(edge_mode) && $stable(ev_in))
        |-> !tick);
endmodule

// File: rtl/epc_run_gate.sv
`timescale 1ns/1ps
// Run gate: opens and closes the counting window in the gated modes.
// A start is accepted only while idle. A stop is accepted only while running.
// Outside the gated modes the window is forced closed.
module epc_run_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic gated,
    input  logic start_hit,
    input  logic stop_hit,
    output logic running,
    output logic start_now,
    output logic stop_now
);
    assign start_now = gated && !running && start_hit;
    assign stop_now  = gated && running && stop_hit;

    // Track whether the window is open.
    always_ff @(posedge clk) begin
        if (!rst_n)         running <= 1'b0;
        else if (!gated)    running <= 1'b0;
        else if (start_now) running <= 1'b1;
        else if (stop_now)  running <= 1'b0;
    end

    // R8: a running window stays open until a stop (re-starts ignored).
    a_r8_hold_run: assert property (@(posedge clk) disable iff (!rst_n)
        (gated && running && !stop_hit) |=> running);
    // R12: simultaneous start and stop while idle opens the window.
    a_r12_start_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (gated && !running && start_hit && stop_hit) |=> running);
endmodule

// File: rtl/epc_count_core.sv
`timescale 1ns/1ps
// Count core: the counter, the sticky overflow flag, the match pulse and the
// peak register. Assumes tick, start_now and stop_now are valid for the cycle
// in which they are presented.
module epc_count_core
    import epc_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cnt_mode_e        mode,
    input  logic             timer_hold,
    input  logic             tick,
    input  logic             running,
    input  logic             start_now,
    input  logic             stop_now,
    input  logic [CNT_W-1:0] ref_val,
    input  logic             ovf_clr,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] max_count,
    output logic             overflow,
    output logic             match
);
    logic             gated;
    logic             advance;
    logic             hit;
    logic             wraps;
    logic [CNT_W-1:0] incr;

    assign gated   = (mode == MODE_GATED) || (mode == MODE_PEAK) || (mode == MODE_ACCUM);
    assign advance = gated ? (running && !stop_now && tick) : tick;
    assign incr    = count + 1'b1;
    assign hit     = advance && (incr == ref_val);
    assign wraps   = advance && (count == '1);

    // Counter update per mode.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (start_now && mode == MODE_GATED)
            count <= '0;
        else if (stop_now && mode == MODE_PEAK)
            count <= '0;
        else if (advance)
            count <= (mode == MODE_TIMER && !timer_hold && hit) ? '0 : incr;
    end

    // Peak capture at each stop in peak mode.
    always_ff @(posedge clk) begin
        if (!rst_n)
            max_count <= '0;
        else if (stop_now && mode == MODE_PEAK && count > max_count)
            max_count <= count;
    end

    // Sticky overflow; a wrap wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       overflow <= 1'b0;
        else if (wraps)   overflow <= 1'b1;
        else if (ovf_clr) overflow <= 1'b0;
    end

    // One-cycle match pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) match <= 1'b0;
        else        match <= hit;
    end

    // R1: the count only grows, except when it returns to zero.
    a_r1_up_only: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (count == '0 || count >= $past(count)));
    // R5: overflow is sticky until cleared.
    a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !ovf_clr) |=> overflow);
    // R10: the peak register never shrinks.
    a_r10_peak_grows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (max_count >= $past(max_count)));
    // R11: a stop in accumulate mode freezes the count.
    a_r11_accum_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_ACCUM && stop_now) |=> (count == $past(count)));
endmodule

// File: rtl/event_profile_counter.sv
`timescale 1ns/1ps
// Multi-mode event profiling counter: top level.
// Connects the event front end, the run gate and the count core.
// All configuration pins are assumed quasi-static while a measurement runs.
module event_profile_counter
    import epc_pkg::*;
#(
    parameter  int CNT_W  = 32,
    parameter  int NUM_EV = 8,
    localparam int SEL_W  = $clog2(NUM_EV + 1),
    localparam int IDX_W  = (NUM_EV > 1) ? $clog2(NUM_EV) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EV-1:0] ev_in,
    input  logic [SEL_W-1:0]  cnt_sel,
    input  logic              edge_mode,
    input  logic [2:0]        mode_sel,
    input  logic              timer_hold,
    input  logic [IDX_W-1:0]  start_sel,
    input  logic [IDX_W-1:0]  stop_sel,
    input  logic [CNT_W-1:0]  ref_val,
    input  logic              ovf_clr,
    output logic [CNT_W-1:0]  count,
    output logic [CNT_W-1:0]  max_count,
    output logic              overflow,
    output logic              match,
    output logic              running
);
    cnt_mode_e mode;
    logic      gated;
    logic      tick;
    logic      start_hit;
    logic      stop_hit;
    logic      start_now;
    logic      stop_now;

    assign mode  = cnt_mode_e'(mode_sel);
    assign gated = (mode == MODE_GATED) || (mode == MODE_PEAK) || (mode == MODE_ACCUM);

    epc_event_front #(.NUM_EV(NUM_EV), .SEL_W(SEL_W), .IDX_W(IDX_W)) u_front (
        .clk(clk), .rst_n(rst_n), .ev_in(ev_in), .cnt_sel(cnt_sel),
        .edge_mode(edge_mode), .start_sel(start_sel), .stop_sel(stop_sel),
        .tick(tick), .start_hit(start_hit), .stop_hit(stop_hit)
    );

    epc_run_gate u_gate (
        .clk(clk), .rst_n(rst_n), .gated(gated), .start_hit(start_hit),
        .stop_hit(stop_hit), .running(running), .start_now(start_now),
        .stop_now(stop_now)
    );

    epc_count_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .mode(mode), .timer_hold(timer_hold),
        .tick(tick), .running(running), .start_now(start_now),
        .stop_now(stop_now), .ref_val(ref_val), .ovf_clr(ovf_clr),
        .count(count), .max_count(max_count), .overflow(overflow),
        .match(match)
    );
endmodule

// File: tb/test_event_profile_counter.sv
`timescale 1ns/1ps
module test_event_profile_counter;
    localparam int CNT_W  = 8;
    localparam int NUM_EV = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [3:0]       ev_in = '0;
    logic [2:0]       cnt_sel = '0;
    logic             edge_mode = 1'b0;
    logic [2:0]       mode_sel = '0;
    logic             timer_hold = 1'b0;
    logic [1:0]       start_sel = 2'd2;
    logic [1:0]       stop_sel = 2'd3;
    logic [7:0]       ref_val = '0;
    logic             ovf_clr = 1'b0;
    logic [7:0]       count;
    logic [7:0]       max_count;
    logic             overflow;
    logic             match;
    logic             running;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    event_profile_counter #(.CNT_W(CNT_W), .NUM_EV(NUM_EV)) i_event_profile_counter (
        .clk(clk), .rst_n(rst_n), .ev_in(ev_in), .cnt_sel(cnt_sel),
        .edge_mode(edge_mode), .mode_sel(mode_sel), .timer_hold(timer_hold),
        .start_sel(start_sel), .stop_sel(stop_sel), .ref_val(ref_val),
        .ovf_clr(ovf_clr), .count(count), .max_count(max_count),
        .overflow(overflow), .match(match), .running(running)
    );

    always #4 clk = ~clk;

    // Vector: [23:21] cnt_sel, [20] edge_mode, [19:16] ev level, [15:8] edges held, [7:0] expected count
    localparam logic [23:0] VEC [7] = '{
        {3'd1, 1'b0, 4'b0001, 8'd25, 8'd25},  // R3 duration, held 25
        {3'd1, 1'b1, 4'b0001, 8'd25, 8'd1},   // R4 edge, held 25
        {3'd0, 1'b0, 4'b0000, 8'd10, 8'd10},  // R2 no source = every cycle
        {3'd0, 1'b1, 4'b0000, 8'd5,  8'd5},   // R2 every cycle in edge mode
        {3'd2, 1'b0, 4'b0001, 8'd7,  8'd0},   // R2 unselected input
        {3'd4, 1'b0, 4'b1000, 8'd3,  8'd3},   // R2 highest input
        {3'd6, 1'b0, 4'b1111, 8'd5,  8'd0}    // R2 out-of-range select
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        ev_in = '0;
        step(2);
        rst_n = 1'b1;
    endtask

    task automatic pulse(input logic [3:0] bits);
        ev_in = bits;
        step(1);
        ev_in = '0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        step(1);
        do_reset();
        check("R1 count", 32'(count), 0);
        check("R1 max_count", 32'(max_count), 0);
        check("R1 overflow", 32'(overflow), 0);
        check("R1 match", 32'(match), 0);
        check("R1 running", 32'(running), 0);

        // Table walk, free-running mode
        mode_sel = 3'd0;
        for (int v = 0; v < 7; v++) begin
            cnt_sel   = VEC[v][23:21];
            edge_mode = VEC[v][20];
            do_reset();
            ev_in = VEC[v][19:16];
            step(int'(VEC[v][15:8]));
            ev_in = '0;
            check($sformatf("R2/R3/R4 vector %0d", v), 32'(count), 32'(VEC[v][7:0]));
        end

        // R4 toggling source counted in edge mode
        cnt_sel = 3'd1; edge_mode = 1'b1;
        do_reset();
        for (int k = 0; k < 5; k++) begin
            ev_in = (k % 2 == 0) ? 4'b0001 : 4'b0000;
            step(1);
        end
        ev_in = '0;
        check("R4 toggles", 32'(count), 3);

        // R5 wrap and sticky overflow
        cnt_sel = 3'd0; edge_mode = 1'b0; ref_val = 8'd0;
        do_reset();
        step(255);
        check("R5 before wrap", 32'(count), 255);
        check("R5 no overflow yet", 32'(overflow), 0);
        step(1);
        check("R5 wrapped", 32'(count), 0);
        check("R5 overflow set", 32'(overflow), 1);
        step(3);
        check("R5 overflow sticky", 32'(overflow), 1);
        ovf_clr = 1'b1;
        step(1);
        ovf_clr = 1'b0;
        check("R5 overflow cleared", 32'(overflow), 0);

        // R6/R7 timer mode, return to zero
        mode_sel = 3'd1; ref_val = 8'd5; timer_hold = 1'b0;
        do_reset();
        step(4);
        check("R6 no match early", 32'(match), 0);
        step(1);
        check("R7 timer returns to zero", 32'(count), 0);
        check("R6 match on reach", 32'(match), 1);
        step(1);
        check("R7 timer restarted", 32'(count), 1);
        check("R6 match one cycle", 32'(match), 0);

        // R7 timer mode, keep counting
        timer_hold = 1'b1;
        do_reset();
        step(5);
        check("R7 hold reaches ref", 32'(count), 5);
        check("R6 match with hold", 32'(match), 1);
        step(1);
        check("R7 hold continues", 32'(count), 6);
        check("R6 match cleared", 32'(match), 0);

        // R8/R9 gated mode
        mode_sel = 3'd2; ref_val = 8'd0;
        do_reset();
        step(3);
        check("R8 idle no count", 32'(count), 0);
        pulse(4'b0100);
        check("R8 running after start", 32'(running), 1);
        step(4);
        check("R8 counting window", 32'(count), 4);
        pulse(4'b1000);
        check("R9 stop holds", 32'(count), 4);
        check("R8 stopped", 32'(running), 0);
        step(3);
        check("R9 held while idle", 32'(count), 4);
        pulse(4'b0100);
        check("R9 start clears", 32'(count), 0);
        step(2);
        pulse(4'b0100);
        step(2);
        check("R8 restart ignored", 32'(count), 5);
        check("R8 still running", 32'(running), 1);
        pulse(4'b1000);

        // R12 simultaneous start and stop while idle
        do_reset();
        pulse(4'b1100);
        check("R12 start wins", 32'(running), 1);
        step(2);
        check("R12 counting", 32'(count), 2);

        // R10 peak mode
        mode_sel = 3'd3;
        do_reset();
        pulse(4'b0100); step(3); pulse(4'b1000);
        check("R10 first peak", 32'(max_count), 3);
        check("R10 count cleared", 32'(count), 0);
        pulse(4'b0100); step(6); pulse(4'b1000);
        check("R10 larger peak", 32'(max_count), 6);
        pulse(4'b0100); step(2); pulse(4'b1000);
        check("R10 smaller window kept", 32'(max_count), 6);
        check("R10 count cleared again", 32'(count), 0);

        // R11 accumulate mode
        mode_sel = 3'd4;
        do_reset();
        pulse(4'b0100); step(3); pulse(4'b1000);
        check("R11 paused value", 32'(count), 3);
        step(2);
        check("R11 frozen", 32'(count), 3);
        pulse(4'b0100); step(4); pulse(4'b1000);
        check("R11 resumed sum", 32'(count), 7);
        check("R11 max untouched", 32'(max_count), 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule